// File: doc/BRIEF.md
# Dual-Width Read-Only Array Interface

This block is the read side of a 16-bit read-only store. It decodes a chip select, an output gate, a width select and an identifier-detect input, and from them decides what goes onto a 16-bit data bus and when. In word mode every data bit carries array data. In byte mode one extra low-order address input picks the upper or lower half of the addressed word, and that byte appears on the low eight data lines. In byte mode the top data line is not driven, because on a pin-level part that line doubles as the extra address input. With the identifier input raised, the bus shows a fixed maker code or part code instead of array data.

Tri-stating is given as a per-bit drive mask (`dataDrive`) next to the data value, so a pad ring or board model can build the real three-state pins. Access times are counted in clock cycles. The clock period and the nanosecond delays are parameters, and the cycle counts are derived from them. While an access is still settling, `dataValid` stays low and the data lines read zero. The array image is computed from the address. Locations at or above a programmed limit read as erased (all ones).

Top module: `dualwidth_rom_if`

## Requirements
- R1: With `wideSel`=1 and both enables low, all 16 `dataDrive` bits are 1 and a valid read returns the full 16-bit word at `addr`.
- R2: With `wideSel`=0, a valid read returns on `dataOut[7:0]` the lower byte of the word when `hiSel`=0 and the upper byte when `hiSel`=1.
- R3: With `wideSel`=0, `dataDrive[15:8]` and `dataOut[15:8]` are 0; `dataDrive[7:0]` are 1 while the bus is on.
- R4: The bus is driven only when `ceN` and `oeN` were both 0 at the previous clock edge. `oeN`=1 with `ceN`=0 gives `dataDrive`=0.
- R5: `ceN`=1 (standby) gives `dataDrive`=0 and `dataValid`=0 whatever `oeN` does.
- R6: With `idDetect`=1 and a valid read, `addr[0]`=0 returns 0x20 and `addr[0]`=1 returns 0xB1 on `dataOut[7:0]`. In word mode the same code is repeated on `dataOut[15:8]`.
- R7: A change of `addr`, `hiSel`, `wideSel` or `idDetect`, or a fall of `ceN`, holds `dataValid` at 0 and `dataOut` at 0 until the inputs have been sampled unchanged, with `ceN` low, on ceil(100 ns / period) consecutive edges (5 edges at 20 ns).
- R8: After `oeN` falls, `dataValid` stays 0 until `oeN` has been sampled low on ceil(50 ns / period) consecutive edges (3 at 20 ns).
- R9: When either enable rises, `dataDrive` returns to 0 after the next clock edge, which is within 45 ns at the default period.
- R10: Array word at address `a` (word-addressed, `a` below 4096) is {a[15:8] XOR 0xC3, a[7:0]}. Every address from 4096 upward reads 0xFFFF (erased).
- R11: During and right after reset, `dataDrive`=0, `dataValid`=0 and `dataOut`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to count access delays |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Word address |
| hiSel | input | 1 | Half-word select in byte mode (1 = upper byte); the low address bit below `addr[0]` |
| wideSel | input | 1 | 1 = word mode, 0 = byte mode |
| idDetect | input | 1 | 1 = return identifier codes instead of array data |
| ceN | input | 1 | Active-low chip select; high = standby |
| oeN | input | 1 | Active-low output gate |
| dataOut | output | 16 | Data value; zero while not valid |
| dataDrive | output | 16 | Per-bit drive enable; 0 = high impedance |
| dataValid | output | 1 | Access delays have elapsed for the current read |

## Verification
The hardest case to set up from the ports is a read whose access timer is restarted again and again before it can expire, while the bus stays enabled. The case also has to show that the bus keeps driving with zeroed data and never flashes a stale valid word. The stimulus moves the address every three cycles in word mode, which is shorter than the five-cycle access window. It then flips only the byte-half select in byte mode, drops chip select again while the address is held, and finally lowers the output gate late. The reference model tracks each restart cycle by cycle, so the exact edge on which `dataValid` rises is compared in every case.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef struct packed {
    logic busOn;   // both enables were low at the last edge
    logic dataOk;  // access and gate delays have elapsed
  } rd_strobe_t;

  localparam logic [7:0] MAKER_CODE = 8'h20;
  localparam logic [7:0] PART_CODE  = 8'hB1;

  function automatic int unsigned cyclesFor(int unsigned delayNs, int unsigned clkNs);
    return (delayNs + clkNs - 1) / clkNs;
  endfunction

endpackage

// File: rtl/rd_timing_ctrl.sv
module rd_timing_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned ACC_NS = 100,
  parameter int unsigned OE_NS  = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hiSel,
  input  logic              wideSel,
  input  logic              idDetect,
  input  logic              ceN,
  input  logic              oeN,
  output rd_strobe_t        strobe
);

  localparam int unsigned ACC_CYC = cyclesFor(ACC_NS, CLK_NS);
  localparam int unsigned OE_CYC  = cyclesFor(OE_NS, CLK_NS);
  localparam int unsigned ACC_W   = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC + 1);
  localparam int unsigned OE_W    = (OE_CYC < 2) ? 1 : $clog2(OE_CYC + 1);
  localparam int unsigned KEY_W   = ADDR_W + 3;
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(ACC_CYC);
  localparam logic [OE_W-1:0]  OE_MAX  = OE_W'(OE_CYC);

  logic [KEY_W-1:0] keyNow, keyReg;
  logic             ceReg, oeReg;
  logic [ACC_W-1:0] accCnt;
  logic [OE_W-1:0]  oeCnt;
  logic             keyChanged;

  assign keyNow     = {addr, hiSel, wideSel, idDetect};
  assign keyChanged = (keyNow != keyReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= '0;
      ceReg  <= 1'b1;
      oeReg  <= 1'b1;
      accCnt <= '0;
      oeCnt  <= '0;
    end else begin
      keyReg <= keyNow;
      ceReg  <= ceN;
      oeReg  <= oeN;

      if (ceN)                      accCnt <= '0;
      else if (keyChanged || ceReg) accCnt <= ACC_W'(1);
      else if (accCnt != ACC_MAX)   accCnt <= accCnt + ACC_W'(1);

      if (oeN)                      oeCnt <= '0;
      else if (oeReg)               oeCnt <= OE_W'(1);
      else if (oeCnt != OE_MAX)     oeCnt <= oeCnt + OE_W'(1);
    end
  end

  always_comb begin
    strobe.busOn  = !ceReg && !oeReg;
    strobe.dataOk = !ceReg && !oeReg && (accCnt == ACC_MAX) && (oeCnt == OE_MAX);
  end

  // R7: a sampled change while selected invalidates the next cycle
  assert_restart_on_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && keyChanged) |=> !strobe.dataOk);

  // R8: the output gate falling starts a fresh gate delay
  assert_gate_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && oeReg) |=> !strobe.dataOk);

  // R5: standby releases the bus on the following cycle
  assert_standby_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!strobe.busOn && !strobe.dataOk));

endmodule

// File: rtl/rd_array_path.sv
module rd_array_path
  import eprom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PROG_WORDS = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hiSel,
  input  logic              wideSel,
  input  logic              idDetect,
  input  rd_strobe_t        strobe,
  output logic [15:0]       dataOut,
  output logic [15:0]       dataDrive,
  output logic              dataValid
);

  localparam logic [15:0] WORD_MASK = 16'hFFFF;
  localparam logic [15:0] BYTE_MASK = 16'h00FF;
  localparam logic [15:0] ERASED    = 16'hFFFF;

  logic [ADDR_W-1:0] addrReg;
  logic              hiReg, wideReg, idReg;
  logic [15:0]       baseWord;
  logic [7:0]        idByte, pickByte;

  function automatic logic [15:0] imageWord(logic [ADDR_W-1:0] a);
    logic [15:0] low16;
    low16 = 16'(a);
    if (32'(a) < PROG_WORDS) return {low16[15:8] ^ 8'hC3, low16[7:0]};
    else                     return ERASED;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      hiReg   <= 1'b0;
      wideReg <= 1'b1;
      idReg   <= 1'b0;
    end else begin
      addrReg <= addr;
      hiReg   <= hiSel;
      wideReg <= wideSel;
      idReg   <= idDetect;
    end
  end

  always_comb begin
    idByte   = addrReg[0] ? PART_CODE : MAKER_CODE;
    baseWord = idReg ? {idByte, idByte} : imageWord(addrReg);
    pickByte = hiReg ? baseWord[15:8] : baseWord[7:0];
    dataDrive = strobe.busOn ? (wideReg ? WORD_MASK : BYTE_MASK) : '0;
    if (!strobe.dataOk)  dataOut = '0;
    else if (wideReg)    dataOut = baseWord;
    else                 dataOut = {8'h00, pickByte};
    dataValid = strobe.dataOk;
  end

  // R6: identifier reads at even address show the maker code
  assert_maker_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && idReg && !addrReg[0]) |-> (dataOut[7:0] == MAKER_CODE));

endmodule

// File: rtl/dualwidth_rom_if.sv
module dualwidth_rom_if
  import eprom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PROG_WORDS = 4096,
  parameter int unsigned CLK_NS     = 20,
  parameter int unsigned ACC_NS     = 100,
  parameter int unsigned OE_NS      = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hiSel,
  input  logic              wideSel,
  input  logic              idDetect,
  input  logic              ceN,
  input  logic              oeN,
  output logic [15:0]       dataOut,
  output logic [15:0]       dataDrive,
  output logic              dataValid
);

  rd_strobe_t strobe;

  rd_timing_ctrl #(
    .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .ACC_NS(ACC_NS), .OE_NS(OE_NS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .hiSel(hiSel), .wideSel(wideSel),
    .idDetect(idDetect), .ceN(ceN), .oeN(oeN), .strobe(strobe)
  );

  rd_array_path #(
    .ADDR_W(ADDR_W), .PROG_WORDS(PROG_WORDS)
  ) path_i (
    .clk(clk), .rstN(rstN), .addr(addr), .hiSel(hiSel), .wideSel(wideSel),
    .idDetect(idDetect), .strobe(strobe), .dataOut(dataOut),
    .dataDrive(dataDrive), .dataValid(dataValid)
  );

  // R4: valid data only follows an edge where both enables were low
  assert_valid_needs_enables_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ($past(!ceN) && $past(!oeN)));

  // R9: chip select high at an edge leaves the bus undriven afterwards
  assert_release_after_ce_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(ceN) |-> (dataDrive == 16'h0000));

  // R3: byte mode never drives the upper data lines
  assert_byte_upper_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wideSel |=> (dataDrive[15:8] == 8'h00));

endmodule

// File: tb/dualwidth_rom_if_tb_top.sv
module dualwidth_rom_if_tb_top;

  localparam int ACC_EDGES = 5;
  localparam int OE_EDGES  = 3;
  localparam int PROG      = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addr = '0;
  logic        hiSel = 1'b0, wideSel = 1'b1, idDetect = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1;
  logic [15:0] dataOut, dataDrive;
  logic        dataValid;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curReq = "R11";

  // reference state
  logic [22:0] mKey = '0;
  bit          mCe = 1'b1, mOe = 1'b1;
  int          mAcc = 0, mOeC = 0;

  always #10 clk = ~clk;

  dualwidth_rom_if dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .hiSel(hiSel), .wideSel(wideSel),
    .idDetect(idDetect), .ceN(ceN), .oeN(oeN), .dataOut(dataOut),
    .dataDrive(dataDrive), .dataValid(dataValid)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mKey = '0; mCe = 1'b1; mOe = 1'b1; mAcc = 0; mOeC = 0;
    end else begin
      if (ceN) mAcc = 0;
      else if ({addr, hiSel, wideSel, idDetect} != mKey || mCe) mAcc = 1;
      else if (mAcc < ACC_EDGES) mAcc++;
      if (oeN) mOeC = 0;
      else if (mOe) mOeC = 1;
      else if (mOeC < OE_EDGES) mOeC++;
      mKey = {addr, hiSel, wideSel, idDetect};
      mCe = ceN;
      mOe = oeN;
    end
  end

  function automatic logic [15:0] arrayWord(logic [19:0] a);
    if (int'(a) < PROG) return {a[15:8] ^ 8'hC3, a[7:0]};
    return 16'hFFFF;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [19:0] a;
      logic        h, w, id, en, v;
      logic [15:0] eDrv, eDat, word;
      logic [7:0]  code;
      {a, h, w, id} = mKey;
      en   = !mCe && !mOe;
      v    = en && (mAcc >= ACC_EDGES) && (mOeC >= OE_EDGES);
      code = a[0] ? 8'hB1 : 8'h20;
      word = id ? {code, code} : arrayWord(a);
      eDrv = en ? (w ? 16'hFFFF : 16'h00FF) : 16'h0000;
      eDat = !v ? 16'h0000 : (w ? word : {8'h00, (h ? word[15:8] : word[7:0])});
      vectors++;
      if (dataDrive !== eDrv || dataOut !== eDat || dataValid !== v) begin
        fails++;
        $display("FAIL %s t=%0t drive=%h exp %h data=%h exp %h valid=%b exp %b",
                 curReq, $time, dataDrive, eDrv, dataOut, eDat, dataValid, v);
      end
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIn(logic [19:0] a, logic h, logic w, logic id, logic c, logic o);
    addr = a; hiSel = h; wideSel = w; idDetect = id; ceN = c; oeN = o;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s", curReq);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    curReq = "R11";
    hold(3);
    rstN = 1'b1;
    hold(2);

    // R1: word reads
    curReq = "R1";
    setIn(20'h00000, 0, 1, 0, 0, 0); hold(8);
    setIn(20'h00005, 0, 1, 0, 0, 0); hold(8);
    setIn(20'h00ABC, 0, 1, 0, 0, 0); hold(8);

    // R10: programmed boundary and erased space
    curReq = "R10";
    setIn(20'h00FFF, 0, 1, 0, 0, 0); hold(7);
    setIn(20'h01000, 0, 1, 0, 0, 0); hold(7);
    setIn(20'hFFFFF, 0, 1, 0, 0, 0); hold(7);

    // R2: byte halves
    curReq = "R2";
    setIn(20'h00123, 0, 0, 0, 0, 0); hold(7);
    setIn(20'h00123, 1, 0, 0, 0, 0); hold(7);

    // R3: upper lines quiet in byte mode
    curReq = "R3";
    setIn(20'h00456, 1, 0, 0, 0, 0); hold(7);
    setIn(20'h00456, 0, 0, 0, 0, 0); hold(2);
    setIn(20'h00456, 1, 0, 0, 0, 0); hold(7);

    // R7: repeated restarts and chip select fall
    curReq = "R7";
    setIn(20'h00010, 0, 1, 0, 0, 0); hold(3);
    setIn(20'h00011, 0, 1, 0, 0, 0); hold(3);
    setIn(20'h00012, 0, 1, 0, 0, 0); hold(7);
    setIn(20'h00012, 0, 1, 0, 1, 0); hold(2);
    setIn(20'h00012, 0, 1, 0, 0, 0); hold(7);
    setIn(20'h00012, 0, 0, 0, 0, 0); hold(7);

    // R8: late output gate
    curReq = "R8";
    setIn(20'h00033, 0, 1, 0, 0, 1); hold(8);
    setIn(20'h00033, 0, 1, 0, 0, 0); hold(6);

    // R4: gate high while selected
    curReq = "R4";
    setIn(20'h00033, 0, 1, 0, 0, 1); hold(5);

    // R5: standby ignores the gate
    curReq = "R5";
    setIn(20'h00033, 0, 1, 0, 1, 0); hold(3);
    setIn(20'h00033, 0, 1, 0, 1, 1); hold(3);
    setIn(20'h00033, 0, 1, 0, 1, 0); hold(3);

    // R6: identifier codes
    curReq = "R6";
    setIn(20'h00000, 0, 1, 1, 0, 0); hold(7);
    setIn(20'h00001, 0, 1, 1, 0, 0); hold(7);
    setIn(20'h00001, 0, 0, 1, 0, 0); hold(7);
    setIn(20'h00000, 1, 0, 1, 0, 0); hold(7);

    // R9: release on either enable rising
    curReq = "R9";
    setIn(20'h00077, 0, 1, 0, 0, 0); hold(7);
    setIn(20'h00077, 0, 1, 0, 1, 0); hold(2);
    setIn(20'h00077, 0, 1, 0, 0, 0); hold(7);
    setIn(20'h00077, 0, 1, 0, 0, 1); hold(2);

    // R11: reset in the middle of a read
    curReq = "R11";
    setIn(20'h00077, 0, 1, 0, 0, 0); hold(7);
    rstN = 1'b0; hold(2);
    rstN = 1'b1; hold(7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule